// File: doc/BRIEF.md
# Radix-4 Booth Sequential Multiplier

This block multiplies two signed two's-complement operands over several clock cycles. Each cycle it consumes two bits of the multiplier. A recoder looks at those two bits and at the bit consumed just before them, and picks one of five actions: add nothing, add or subtract the multiplicand, or add or subtract twice the multiplicand. The chosen value is applied to a running upper-half accumulator. The accumulator carries two guard bits and feeds an adder two bits wider than the operands.

After each step the accumulator and the lower result register shift right together by two places as one arithmetic value. The multiplier bits leave the bottom of the lower register while product bits enter at its top. A 32-bit operand pair therefore finishes in 16 steps. The full signed product is then available as an upper word and a lower word.

A caller pulses `start` with both operands while the block is idle. It then waits for the one-cycle `done` pulse and reads the two result words. Those words stay unchanged until the next accepted start.

Top module: `booth_mul_seq`

## Requirements
- R1: After reset, `busy_o` and `done_o` are 0 and both result words read 0.
- R2: A `start` sampled high while the block is idle captures both operands and raises `busy_o` at the next clock edge.
- R3: When `done_o` is high, `{hi_o, lo_o}` equals the full signed product of the captured operands, 2*WIDTH bits wide.
- R4: `done_o` is high for exactly one cycle. It rises WIDTH/2 clock edges after the edge that accepted `start`. It is never high together with `busy_o`.
- R5: A `start` pulse while `busy_o` is high is ignored: the operands in progress are not replaced and the result still belongs to the first pair.
- R6: While idle and with no `start`, `hi_o` and `lo_o` hold their values.
- R7: Extreme operands give exact results: the most negative value squared is +2^(2*WIDTH-2), and the most negative value times -1 is +2^(WIDTH-1).
- R8: Each step recodes the triple (bit 1, bit 0, previous bit), with the previous bit starting at 0. The codes 000 and 111 select 0; 001 and 010 select +1x; 011 selects +2x; 100 selects -2x; 101 and 110 select -1x.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a multiply; accepted only while idle |
| mcand_i | input | WIDTH | Signed multiplicand |
| mplier_i | input | WIDTH | Signed multiplier |
| busy_o | output | 1 | Iterations in progress |
| done_o | output | 1 | One-cycle pulse when the result is ready |
| hi_o | output | WIDTH | Upper word of the signed product |
| lo_o | output | WIDTH | Lower word of the signed product |

## Verification
A 6-bit instance is swept over every operand pair. This reaches every recoding triple in every position, including the step where the multiplier's sign bit is recoded. Any wrong table entry or wrong shift alignment therefore shows up in some product. The 32-bit instance gets the extremes: most negative squared, most negative times -1, and zero and ±1 against large values. These separate a correct guard-bit sign extension from a truncated accumulator. Random 32-bit pairs then cover general carry patterns. Separate runs pulse `start` mid-operation and idle for several cycles after `done`, to show that the operands in progress are kept and that the outputs hold.

// File: rtl/booth_pkg.sv
package booth_pkg;
   // Action chosen for one radix-4 step
   typedef struct packed {
      logic act;   // 1: accumulate, 0: leave accumulator unchanged
      logic neg;   // 1: subtract selected value
      logic dbl;   // 1: use twice the multiplicand
   } booth_op_t;
endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
   import booth_pkg::*;
(
   input  logic [2:0] trip_i,   // {bit1, bit0, previous bit}
   output booth_op_t  op_o
);
   always_comb begin
      unique case (trip_i)
         3'b001, 3'b010: op_o = '{act: 1'b1, neg: 1'b0, dbl: 1'b0};
         3'b011:         op_o = '{act: 1'b1, neg: 1'b0, dbl: 1'b1};
         3'b100:         op_o = '{act: 1'b1, neg: 1'b1, dbl: 1'b1};
         3'b101, 3'b110: op_o = '{act: 1'b1, neg: 1'b1, dbl: 1'b0};
         default:        op_o = '{act: 1'b0, neg: 1'b0, dbl: 1'b0};
      endcase
   end

   // doubled values only arise from the two edge triples
   always_comb begin
      if (op_o.dbl)
         AST_DBL_EDGE: assert (trip_i == 3'b011 || trip_i == 3'b100); // R8
   end
endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
   import booth_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0]   mcand_i,
   input  logic [WIDTH+1:0]   acc_i,
   input  booth_op_t          op_i,
   output logic [WIDTH+1:0]   sum_o
);
   localparam int EXT = WIDTH + 2;

   logic [EXT-1:0] ext, sel;

   assign ext = {{2{mcand_i[WIDTH-1]}}, mcand_i};
   assign sel = op_i.dbl ? {ext[EXT-2:0], 1'b0} : ext;

   always_comb begin
      if (!op_i.act)     sum_o = acc_i;
      else if (op_i.neg) sum_o = acc_i - sel;
      else               sum_o = acc_i + sel;
   end
endmodule

// File: rtl/booth_seq_ctrl.sv
module booth_seq_ctrl #(
   parameter int ITER = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic load_o,
   output logic step_o,
   output logic busy_o,
   output logic done_o
);
   localparam int CW = (ITER > 1) ? $clog2(ITER) : 1;
   localparam logic [CW-1:0] LAST = CW'(ITER - 1);

   logic [CW-1:0] cnt_q;
   logic          busy_q, done_q;

   assign load_o = start_i & ~busy_q;
   assign step_o = busy_q;
   assign busy_o = busy_q;
   assign done_o = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (load_o) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
         end else if (busy_q) begin
            if (cnt_q == LAST) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q); // R4
   AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy_q && done_q)); // R4
   AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_q) |=> busy_q); // R2
endmodule

// File: rtl/booth_mul_seq.sv
module booth_mul_seq
   import booth_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [WIDTH-1:0] mcand_i,
   input  logic [WIDTH-1:0] mplier_i,
   output logic             busy_o,
   output logic             done_o,
   output logic [WIDTH-1:0] hi_o,
   output logic [WIDTH-1:0] lo_o
);
   localparam int ITER = WIDTH / 2;
   localparam int EXT  = WIDTH + 2;

   generate
      if (WIDTH < 4 || (WIDTH % 2) != 0) begin : g_bad_width
         $error("booth_mul_seq: WIDTH must be even and at least 4");
      end
   endgenerate

   logic [WIDTH-1:0] mcand_q, lo_q;
   logic [EXT-1:0]   hi_q, sum;
   logic             prev_q, load, step;
   booth_op_t        op;

   booth_seq_ctrl #(.ITER(ITER)) ctrl_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start),
      .load_o  (load),
      .step_o  (step),
      .busy_o  (busy_o),
      .done_o  (done_o)
   );

   booth_recoder rec_i (
      .trip_i ({lo_q[1:0], prev_q}),
      .op_o   (op)
   );

   booth_addsub #(.WIDTH(WIDTH)) add_i (
      .mcand_i (mcand_q),
      .acc_i   (hi_q),
      .op_i    (op),
      .sum_o   (sum)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mcand_q <= '0;
         lo_q    <= '0;
         hi_q    <= '0;
         prev_q  <= 1'b0;
      end else if (load) begin
         mcand_q <= mcand_i;
         lo_q    <= mplier_i;
         hi_q    <= '0;
         prev_q  <= 1'b0;
      end else if (step) begin
         hi_q    <= {{2{sum[EXT-1]}}, sum[EXT-1:2]};
         lo_q    <= {sum[1:0], lo_q[WIDTH-1:2]};
         prev_q  <= lo_q[1];
      end
   end

   assign hi_o = hi_q[WIDTH-1:0];
   assign lo_o = lo_q;

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (hi_q[EXT-1:WIDTH-1] == '0 || hi_q[EXT-1:WIDTH-1] == '1)); // R3
   AST_OPND_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> $stable(mcand_q)); // R5
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start) |=> ($stable(hi_o) && $stable(lo_o))); // R6
endmodule

// File: tb/booth_mul_seq_tb_top.sv
module booth_mul_seq_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int W  = 32;
   localparam int WS = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   int n_chk = 0;
   int n_fail = 0;

   // 32-bit instance
   logic          st;
   logic [W-1:0]  a, b, hi, lo;
   logic          busy, done;
   booth_mul_seq #(.WIDTH(W)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(st), .mcand_i(a), .mplier_i(b),
      .busy_o(busy), .done_o(done), .hi_o(hi), .lo_o(lo));

   // small instance for exhaustive sweep
   logic          st_s;
   logic [WS-1:0] a_s, b_s, hi_s, lo_s;
   logic          busy_s, done_s;
   booth_mul_seq #(.WIDTH(WS)) dut_sm_i (
      .clk(clk), .rst_n(rst_n), .start(st_s), .mcand_i(a_s), .mplier_i(b_s),
      .busy_o(busy_s), .done_o(done_s), .hi_o(hi_s), .lo_o(lo_s));

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one 32-bit multiply; optional mid-run start with other operands
   task automatic run32(input logic [W-1:0] x, input logic [W-1:0] y,
                        input string req, input bit poke);
      logic signed [63:0] exp;
      int cyc;
      exp = $signed(x) * $signed(y);
      @(negedge clk); a = x; b = y; st = 1'b1;
      @(negedge clk); st = 1'b0;
      chk(busy == 1'b1, "R2", {63'd0, busy}, 64'd1);
      cyc = 1;
      while (!done && cyc < 100) begin
         @(negedge clk);
         cyc++;
         if (poke && cyc == 3) begin
            a = ~x; b = y + 32'd7; st = 1'b1;     // R5: must be ignored
         end else begin
            st = 1'b0;
         end
      end
      chk(cyc == W / 2 + 1, "R4", 64'(cyc), 64'(W / 2 + 1));
      chk({hi, lo} == exp, req, {hi, lo}, exp);
      @(negedge clk);
      chk(done == 1'b0, "R4", {63'd0, done}, 64'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [63:0] held;
      int cyc;
      logic signed [11:0] e6;
      st = 1'b0; a = '0; b = '0;
      st_s = 1'b0; a_s = '0; b_s = '0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!busy && !done && hi == '0 && lo == '0, "R1", {hi, lo}, 64'd0);
      chk(!busy_s && !done_s && hi_s == '0 && lo_s == '0, "R1",
          64'({hi_s, lo_s}), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R7 extremes
      run32(32'h8000_0000, 32'h8000_0000, "R7", 1'b0);
      run32(32'h8000_0000, 32'hFFFF_FFFF, "R7", 1'b0);
      run32(32'hFFFF_FFFF, 32'h8000_0000, "R7", 1'b0);
      run32(32'h7FFF_FFFF, 32'h8000_0000, "R7", 1'b0);
      run32(32'h7FFF_FFFF, 32'h7FFF_FFFF, "R3", 1'b0);
      run32(32'h0000_0000, 32'h8000_0000, "R3", 1'b0);
      run32(32'h0000_0001, 32'hFFFF_FFFF, "R3", 1'b0);
      run32(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3", 1'b0);
      run32(32'h5555_5555, 32'hAAAA_AAAA, "R8", 1'b0);
      run32(32'h1234_5678, 32'h3333_3333, "R8", 1'b0);

      // R5 start during busy ignored
      run32(32'hDEAD_BEEF, 32'h0BAD_F00D, "R5", 1'b1);
      run32(32'h8000_0001, 32'h7FFF_FFFE, "R5", 1'b1);

      // R6 outputs hold while idle
      held = {hi, lo};
      repeat (5) @(negedge clk);
      chk({hi, lo} == held, "R6", {hi, lo}, held);

      for (int i = 0; i < 300; i++)
         run32($urandom, $urandom, "R3", 1'b0);

      // exhaustive 6-bit sweep: every recoding triple at every position (R8)
      for (int x = 0; x < (1 << WS); x++) begin
         for (int y = 0; y < (1 << WS); y++) begin
            @(negedge clk); a_s = WS'(x); b_s = WS'(y); st_s = 1'b1;
            @(negedge clk); st_s = 1'b0;
            cyc = 1;
            while (!done_s && cyc < 50) begin
               @(negedge clk);
               cyc++;
            end
            e6 = $signed(a_s) * $signed(b_s);
            chk(cyc == WS / 2 + 1, "R4", 64'(cyc), 64'(WS / 2 + 1));
            chk({hi_s, lo_s} == e6, "R8", 64'({hi_s, lo_s}), 64'(e6));
         end
      end

      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule